// File: doc/BRIEF.md
# Quadrature Oscillator Frequency Shifter

This block takes a stream of complex baseband samples, one in-phase and one quadrature value of 12 bits each, and moves the whole spectrum by a programmable offset. The goal is to bring a chosen signal down to zero frequency. It contains its own numerically controlled oscillator. A phase accumulator steps once for every accepted sample and addresses a sine table. The block forms a full complex product of the input and the oscillator, so the shift creates no image.

A tuning word sets the offset. For an offset of f Hz at the 50 kHz sample rate, the word is f * 2^24 / 50000, which covers 0 to 25 kHz. A direction bit exchanges the cosine and sine buses where they enter the multiplier, and this reverses the direction of the shift without touching the tuning word. Each result is rounded and saturated back to 12 bits. Results leave through registers, two clock cycles after the strobe of the sample they belong to.

Top module: `quad_freq_shifter`

## Requirements
- R1: A synchronous active-high reset clears out_valid, out_i, out_q and the phase accumulator. The first sample after reset is therefore mixed at phase 0, with cosine 2047 and sine 0.
- R2: out_valid is high for one cycle, exactly two clock cycles after each cycle in which in_valid is high. It is never high otherwise.
- R3: The 24-bit phase accumulator wraps modulo 2^24. On each strobe it advances by the tuning word. The sample accepted on a strobe uses the phase value from before that advance.
- R4: tune and swap are sampled only on strobe cycles. A new tuning word first affects the phase of the following strobe's sample. Changes to either input between strobes have no effect.
- R5: The table address is bits 23:14 of the phase. sine(k) = floor(2047*sin(2*pi*k/1024) + 0.5). Cosine is sine((k + 256) mod 1024).
- R6: With swap = 0, out_i = in_i*c + in_q*s and out_q = in_q*c - in_i*s, where c is the cosine and s is the sine, before scaling.
- R7: With swap = 1, the cosine and sine values are exchanged at the multiplier inputs, so c takes the sine value and s takes the cosine value in R6.
- R8: Each 25-bit sum is scaled as (sum + 1024) arithmetically shifted right by 11.
- R9: A scaled result above 2047 gives 2047, and one below -2048 gives -2048. Results never wrap.
- R10: out_i and out_q keep their values between valid pulses.
- R11: A tuning word of 2^23 (a 25 kHz offset) steps the table by 512 entries per sample, so the cosine alternates between 2047 and -2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_i | input | 12 | In-phase input sample, signed |
| in_q | input | 12 | Quadrature input sample, signed |
| tune | input | 24 | Phase step per sample |
| swap | input | 1 | Exchange cosine and sine buses (reverse shift) |
| out_valid | output | 1 | Shifted sample valid |
| out_i | output | 12 | Shifted in-phase sample, signed |
| out_q | output | 12 | Shifted quadrature sample, signed |

## Verification
Some behaviours are checked on every cycle. These are the two-cycle valid latency, the reset values, the output hold between pulses, and the accumulator rules: it moves only on a strobe, by exactly the sampled tuning word. Other results depend on the table contents, so only the bench scenarios can show them. These are the numeric values from the table, the product signs in both swap settings, the rounding, the saturation at both limits, and the 25 kHz alternation. The bench compares each of them with a reference model that tracks the phase independently.

// File: rtl/qfs_pkg.sv
package qfs_pkg;
  localparam real QFS_PI = 3.14159265358979323846;

  // Rounded table entry for a sine of given depth and amplitude
  function automatic int sine_entry(int k, int depth, int amp);
    real ang;
    ang = 2.0 * QFS_PI * real'(k) / real'(depth);
    return $rtoi($floor(real'(amp) * $sin(ang) + 0.5));
  endfunction
endpackage

// File: rtl/qfs_phase_acc.sv
module qfs_phase_acc #(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic [PHASE_W-1:0] inc,
  output logic [PHASE_W-1:0] phase,
  output logic [ADDR_W-1:0]  addr
);
  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (step) phase <= phase + inc;
  end

  // Current (pre-advance) phase selects the table entry
  assign addr = phase[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/qfs_sine_rom.sv
module qfs_sine_rom #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [DATA_W-1:0] sin_q,
  output logic signed [DATA_W-1:0] cos_q
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int QUARTER = DEPTH / 4;
  localparam int AMP     = (1 << (DATA_W - 1)) - 1;

  logic signed [DATA_W-1:0] table_mem [DEPTH];
  logic [ADDR_W-1:0] cos_addr;

  initial begin
    for (int k = 0; k < DEPTH; k++)
      table_mem[k] = DATA_W'(qfs_pkg::sine_entry(k, DEPTH, AMP));
  end

  assign cos_addr = addr + ADDR_W'(QUARTER);

  // Two synchronous read ports, no reset: maps to a dual-port block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      sin_q <= table_mem[addr];
      cos_q <= table_mem[cos_addr];
    end
  end
endmodule

// File: rtl/qfs_cmul.sv
module qfs_cmul #(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] x_q,
  input  logic signed [DATA_W-1:0] lo_c,
  input  logic signed [DATA_W-1:0] lo_s,
  output logic                     y_valid,
  output logic signed [DATA_W-1:0] y_i,
  output logic signed [DATA_W-1:0] y_q
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int SHIFT  = DATA_W - 1;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (SHIFT - 1);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -(MAXV + SUM_W'(1));

  logic signed [SUM_W-1:0] sum_i, sum_q, scl_i, scl_q;

  function automatic logic signed [DATA_W-1:0] clip(logic signed [SUM_W-1:0] v);
    if (v > MAXV)      return MAXV[DATA_W-1:0];
    else if (v < MINV) return MINV[DATA_W-1:0];
    else               return v[DATA_W-1:0];
  endfunction

  always_comb begin
    sum_i = SUM_W'(x_i * lo_c) + SUM_W'(x_q * lo_s);
    sum_q = SUM_W'(x_q * lo_c) - SUM_W'(x_i * lo_s);
    scl_i = (sum_i + HALF) >>> SHIFT;
    scl_q = (sum_q + HALF) >>> SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_valid <= 1'b0;
      y_i     <= '0;
      y_q     <= '0;
    end else begin
      y_valid <= en;
      if (en) begin
        y_i <= clip(scl_i);
        y_q <= clip(scl_q);
      end
    end
  end
endmodule

// File: rtl/quad_freq_shifter.sv
module quad_freq_shifter #(
  parameter int DATA_W  = 12,
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic [PHASE_W-1:0]       tune,
  input  logic                     swap,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);
  logic [PHASE_W-1:0]       phase_q;
  logic [ADDR_W-1:0]        tab_addr;
  logic signed [DATA_W-1:0] rom_sin, rom_cos, bus_c, bus_s;
  logic signed [DATA_W-1:0] s1_i, s1_q;
  logic                     s1_valid, s1_swap;

  qfs_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) acc_i (
    .clk(clk), .rst(rst), .step(in_valid), .inc(tune),
    .phase(phase_q), .addr(tab_addr)
  );

  qfs_sine_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rom_i (
    .clk(clk), .en(in_valid), .addr(tab_addr),
    .sin_q(rom_sin), .cos_q(rom_cos)
  );

  // Stage 1: hold sample and direction aligned with the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_swap  <= 1'b0;
      s1_i     <= '0;
      s1_q     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_swap <= swap;
        s1_i    <= in_i;
        s1_q    <= in_q;
      end
    end
  end

  // Direction control: exchange oscillator buses at the multiplier
  assign bus_c = s1_swap ? rom_sin : rom_cos;
  assign bus_s = s1_swap ? rom_cos : rom_sin;

  // Stage 2: complex multiply, round, saturate, register
  qfs_cmul #(.DATA_W(DATA_W)) mul_i (
    .clk(clk), .rst(rst), .en(s1_valid),
    .x_i(s1_i), .x_q(s1_q), .lo_c(bus_c), .lo_s(bus_s),
    .y_valid(out_valid), .y_i(out_i), .y_q(out_q)
  );
endmodule

// File: rtl/qfs_checker.sv
module qfs_checker #(
  parameter int DATA_W  = 12,
  parameter int PHASE_W = 24
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [PHASE_W-1:0]       tune,
  input logic [PHASE_W-1:0]       phase,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R1: reset leaves outputs and accumulator cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0 && phase == '0));

  // R2: valid follows the strobe by two cycles
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R3: accumulator advances by the sampled tuning word
  p_acc_step_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (phase == $past(phase) + $past(tune)));

  // R4: no strobe, no phase movement
  p_acc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase));

  // R10: outputs hold between valid pulses
  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind quad_freq_shifter qfs_checker #(.DATA_W(DATA_W), .PHASE_W(PHASE_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .tune(tune), .phase(phase_q),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/quad_freq_shifter_tb_top.sv
module quad_freq_shifter_tb_top;
  logic clk = 1'b0;
  logic rst, in_valid, swap;
  logic signed [11:0] in_i, in_q, out_i, out_q;
  logic [23:0] tune;
  logic out_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [23:0] ph;

  always #5 clk = ~clk;

  quad_freq_shifter dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .tune(tune), .swap(swap), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic int ref_sine(int k);
    return $rtoi($floor(2047.0 * $sin(2.0 * 3.14159265358979323846 * real'(k) / 1024.0) + 0.5));
  endfunction

  function automatic int scale_sat(longint s);
    longint r;
    r = (s + 1024) >>> 11;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    ph = '0;
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 out_i", int'(out_i), 0);
    chk("R1 out_q", int'(out_q), 0);
  endtask

  task automatic send(int i, int q, logic [23:0] tw, bit sw, string req);
    int a, c, s, t, ei, eq;
    a = int'(ph[23:14]);
    s = ref_sine(a);
    c = ref_sine((a + 256) % 1024);
    if (sw) begin t = c; c = s; s = t; end
    ei = scale_sat(longint'(i) * c + longint'(q) * s);
    eq = scale_sat(longint'(q) * c - longint'(i) * s);
    @(negedge clk);
    in_i = 12'(i); in_q = 12'(q); tune = tw; swap = sw; in_valid = 1;
    @(negedge clk);
    in_valid = 0; tune = 24'($urandom); swap = 1'($urandom);
    in_i = 12'($urandom); in_q = 12'($urandom);
    chk("R2 early", int'(out_valid), 0);
    @(negedge clk);
    chk("R2 valid", int'(out_valid), 1);
    chk({req, " i"}, int'(out_i), ei);
    chk({req, " q"}, int'(out_q), eq);
    @(negedge clk);
    chk("R2 single", int'(out_valid), 0);
    chk("R10 hold i", int'(out_i), ei);
    chk("R10 hold q", int'(out_q), eq);
    ph = ph + tw;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; in_valid = 0; in_i = 0; in_q = 0; tune = 0; swap = 0;
    do_reset();
    // R1/R5: first sample at phase 0
    send(1000, -500, 24'h400000, 0, "R1 phase0");
    // R3/R5/R6: quarter-turn steps
    send(700, 300, 24'h400000, 0, "R3 R6 quarter");
    send(-900, 1200, 24'h123456, 0, "R4 R6 next");
    // R7: swapped buses
    send(800, -600, 24'h0A0000, 1, "R7 swap");
    send(-1500, 400, 24'h0A0000, 1, "R7 swap2");
    // R11: 25 kHz word
    do_reset();
    for (int n = 0; n < 4; n++)
      send(1000, 0, 24'((64'd25000 << 24) / 64'd50000), 0, "R11 nyquist");
    // R8/R9: saturation at 45 degrees
    do_reset();
    send(0, 0, 24'h200000, 0, "R8 step");
    send(-2048, -2048, 24'h0, 0, "R9 neg sat");
    send(2047, 2047, 24'h0, 0, "R9 pos sat");
    send(-2048, -2048, 24'h0, 1, "R9 swap sat");
    send(3, -1, 24'h0, 0, "R8 round");
    // Random mix
    for (int n = 0; n < 80; n++) begin
      send(int'($signed(12'($urandom))), int'($signed(12'($urandom))),
           24'($urandom), 1'($urandom), "R6 R7 random");
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule